// File: doc/BRIEF.md
# Three-Generator Configurable Logic Cell

This block is a single programmable logic cell. Two 4-input lookup tables (generators F and G) each produce one bit from their own four inputs. A third, 3-input table (generator H) combines the F result, the G result and a dedicated input `h1`. Two combinational outputs and two flip-flops draw on these results. Each flip-flop chooses its data from F, G, H or a direct data pin. The two flip-flops share one clock-enable pin and one set/reset pin. Configuration bits decide whether each flip-flop uses them, and whether set/reset forces the flip-flop high or low.

All behaviour comes from a 54-bit configuration word held inside the cell. The word is loaded serially through `cfg_din`, one bit per clock, while `prog_en` is high. While programming is in progress, all four outputs read low and both flip-flops are cleared. A surrounding fabric would load the word once and then use the cell as a fixed function.

Configuration word layout (bit 0 is the least significant bit):

| Bits | Field |
|------|-------|
| [15:0] | F truth table |
| [31:16] | G truth table |
| [39:32] | H truth table |
| [41:40] | `x` source |
| [43:42] | `y` source |
| [45:44] | `xq` data source |
| [47:46] | `yq` data source |
| [48] | `xq` set/reset value |
| [49] | `xq` set/reset use |
| [50] | `xq` clock-enable use |
| [51] | `yq` set/reset value |
| [52] | `yq` set/reset use |
| [53] | `yq` clock-enable use |

Top module: `clb_cell`

## Requirements
- R1: F equals bit `f_in` of config bits [15:0], with `f_in[3:0]` read as an unsigned index. G equals bit `g_in` of config bits [31:16], indexed the same way.
- R2: H equals bit k of config bits [39:32], where k = {h1, G, F}: F is the index LSB and h1 is the index MSB.
- R3: The `x` source is chosen by config bits [41:40] and the `y` source by bits [43:42]. The codes are 0 for F, 1 for G, and 2 or 3 for H. Both outputs are combinational.
- R4: The `xq` data source is chosen by config bits [45:44] and the `yq` data source by bits [47:46]. The codes are 0 for F, 1 for G, 2 for H and 3 for `din`. The chosen value appears on the output after the next rising clock edge.
- R5: Clock-enable use is set by config bit [50] for `xq` and bit [53] for `yq`. When this bit is 1 and `ec` is 0, the flip-flop keeps its value. When this bit is 0, `ec` is ignored.
- R6: Set/reset use is set by config bit [49] for `xq` and bit [52] for `yq`. When this bit is 1 and `sr` is 1, the flip-flop loads its set/reset value at the clock edge, regardless of `ec`. The set/reset value is config bit [48] for `xq` and bit [51] for `yq`: 1 means set, 0 means reset.
- R7: While `prog_en` is high, each rising clock edge shifts `cfg_din` into config bit 0 and moves every other bit one place up. After 54 edges, the first bit shifted in sits at bit 53, so the word loads MSB first. While `prog_en` is low, the configuration does not change whatever `cfg_din` does.
- R8: While `prog_en` is high, `x`, `y`, `xq` and `yq` are all 0. Both flip-flops are cleared to 0 at each clock edge during programming.
- R9: Asynchronous active-low reset `rst_n` clears the configuration word and both flip-flops, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming enable; shifts the configuration |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| f_in | input | 4 | F generator inputs |
| g_in | input | 4 | G generator inputs |
| h1 | input | 1 | Dedicated third input of the H generator |
| din | input | 1 | Direct flip-flop data input |
| sr | input | 1 | Shared set/reset control |
| ec | input | 1 | Shared clock enable |
| x | output | 1 | Combinational output 0 |
| y | output | 1 | Combinational output 1 |
| xq | output | 1 | Registered output 0 |
| yq | output | 1 | Registered output 1 |

## Verification
The flip-flop properties assume that the configuration word does not change while `prog_en` is low. They also assume that `sr` and `ec` are single-edge controls, sampled only at rising clock edges. The stimulus keeps within these limits by changing every input only on the falling clock edge. It holds `prog_en` high for exactly the 54 edges of a load. It changes no configuration except through a complete serial load or a reset. It toggles `cfg_din` while `prog_en` is low only to show that the stored word stays unchanged.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int SEL_W    = 2;
  localparam int FF_CFG_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_ALT = 2'd3
  } src_e;

  typedef struct packed {
    logic ce_use;
    logic sr_use;
    logic sr_val;
  } ff_cfg_t;

  // Combinational output selection: code 3 also picks H
  function automatic logic pick_comb(src_e s, logic f, logic g, logic h);
    case (s)
      SRC_F:   return f;
      SRC_G:   return g;
      default: return h;
    endcase
  endfunction

  // Flip-flop data selection: code 3 picks the direct data pin
  function automatic logic pick_d(src_e s, logic f, logic g, logic h, logic d);
    case (s)
      SRC_F:   return f;
      SRC_G:   return g;
      SRC_H:   return h;
      default: return d;
    endcase
  endfunction

  // Next state: set/reset wins over clock enable
  function automatic logic ff_next(ff_cfg_t c, logic q, logic d, logic sr, logic ec);
    if (c.sr_use && sr) return c.sr_val;
    if (!c.ce_use || ec) return d;
    return q;
  endfunction
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdin,
  output logic [W-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= '0;
    else if (shift_en) cfg <= {cfg[W-2:0], sdin};
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg));
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter  int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tt,
  input  logic [K-1:0] sel,
  output logic         out
);
  assign out = tt[sel];
endmodule

// File: rtl/clb_ff.sv
module clb_ff
  import clb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    d,
  input  logic    sr,
  input  logic    ec,
  input  ff_cfg_t mode,
  output logic    q
);
  logic sr_hit, ce_block;
  assign sr_hit   = mode.sr_use & sr;
  assign ce_block = mode.ce_use & ~ec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else          q <= ff_next(mode, q, d, sr, ec);
  end

  // R6
  sr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_hit && !clr) |=> (q == $past(mode.sr_val)));
  // R5
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_block && !sr_hit && !clr) |=> $stable(q));
  // R8
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == 1'b0));
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
#(
  parameter int FG_IN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             cfg_din,
  input  logic [FG_IN-1:0] f_in,
  input  logic [FG_IN-1:0] g_in,
  input  logic             h1,
  input  logic             din,
  input  logic             sr,
  input  logic             ec,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  localparam int H_IN    = 3;
  localparam int FG_TT   = 1 << FG_IN;
  localparam int H_TT    = 1 << H_IN;
  localparam int OFS_H   = 2 * FG_TT;
  localparam int OFS_SEL = OFS_H + H_TT;
  localparam int OFS_FF  = OFS_SEL + 4 * SEL_W;
  localparam int CFG_W   = OFS_FF + 2 * FF_CFG_W;

  logic [CFG_W-1:0]            cfg;
  logic [1:0][FG_IN-1:0]       fg_idx;
  logic [1:0]                  fg_o;
  logic                        h_o;
  logic [1:0]                  comb_o, side_d, reg_q;

  clb_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift_en(prog_en), .sdin(cfg_din), .cfg(cfg)
  );

  assign fg_idx = {g_in, f_in};

  // Index 0 is generator F, index 1 is generator G
  for (genvar gi = 0; gi < 2; gi++) begin : g_fg
    clb_lut #(.K(FG_IN)) u_lut (
      .tt(cfg[gi*FG_TT +: FG_TT]), .sel(fg_idx[gi]), .out(fg_o[gi])
    );
  end

  clb_lut #(.K(H_IN)) u_hlut (
    .tt(cfg[OFS_H +: H_TT]), .sel({h1, fg_o[1], fg_o[0]}), .out(h_o)
  );

  // Side 0 drives x/xq, side 1 drives y/yq
  for (genvar s = 0; s < 2; s++) begin : g_side
    assign comb_o[s] = pick_comb(src_e'(cfg[OFS_SEL + SEL_W*s +: SEL_W]),
                                 fg_o[0], fg_o[1], h_o);
    assign side_d[s] = pick_d(src_e'(cfg[OFS_SEL + 2*SEL_W + SEL_W*s +: SEL_W]),
                              fg_o[0], fg_o[1], h_o, din);
    clb_ff u_ff (
      .clk(clk), .rst_n(rst_n), .clr(prog_en), .d(side_d[s]),
      .sr(sr), .ec(ec),
      .mode(ff_cfg_t'(cfg[OFS_FF + FF_CFG_W*s +: FF_CFG_W])),
      .q(reg_q[s])
    );
  end

  assign x  = comb_o[0] & ~prog_en;
  assign y  = comb_o[1] & ~prog_en;
  assign xq = reg_q[0]  & ~prog_en;
  assign yq = reg_q[1]  & ~prog_en;

  // R8
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> !(x | y | xq | yq));
endmodule

// File: tb/tb_clb_cell.sv
module tb_clb_cell;
  localparam int CW = 54;
  localparam int NV = 4;
  localparam logic [CW-1:0] CFGS [NV] = '{
    // {yceu,ysru,yset,xceu,xsru,xset}, ydsel, xdsel, ysel, xsel, H, G, F
    {6'b000000, 2'd3, 2'd2, 2'd1, 2'd0, 8'hE8, 16'h8000, 16'h6996},
    {6'b110111, 2'd1, 2'd0, 2'd3, 2'd2, 8'h96, 16'h0001, 16'hFFFE},
    {6'b011001, 2'd2, 2'd3, 2'd2, 2'd1, 8'h1B, 16'h3C5A, 16'hA5C3},
    {6'b101110, 2'd0, 2'd1, 2'd0, 2'd3, 8'h71, 16'hF00F, 16'h5A5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0, cfg_din = 1'b0;
  logic [3:0] f_in = '0, g_in = '0;
  logic h1 = 1'b0, din = 1'b0, sr = 1'b0, ec = 1'b0;
  logic x, y, xq, yq;
  logic [CW-1:0] cur_cfg = '0;
  logic exq = 1'b0, eyq = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clb_cell dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_din(cfg_din),
    .f_in(f_in), .g_in(g_in), .h1(h1), .din(din), .sr(sr), .ec(ec),
    .x(x), .y(y), .xq(xq), .yq(yq)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic tt_bit(input logic [15:0] t, input int idx);
    return logic'((t >> idx) & 16'd1);
  endfunction

  // Apply one input vector at a falling edge, check comb, clock, check regs
  task automatic apply(input logic [3:0] fi, input logic [3:0] gi, input logic hi,
                       input logic di, input logic sri, input logic eci, input string tag);
    logic f, g, h, ex, ey, dx, dy;
    logic [1:0] xs, ys, xds, yds;
    f_in = fi; g_in = gi; h1 = hi; din = di; sr = sri; ec = eci;
    #1;
    f = tt_bit(cur_cfg[15:0], int'(fi));
    g = tt_bit(cur_cfg[31:16], int'(gi));
    h = tt_bit({8'h00, cur_cfg[39:32]}, int'({hi, g, f}));
    xs = cur_cfg[41:40]; ys = cur_cfg[43:42]; xds = cur_cfg[45:44]; yds = cur_cfg[47:46];
    ex = (xs == 2'd0) ? f : (xs == 2'd1) ? g : h;
    ey = (ys == 2'd0) ? f : (ys == 2'd1) ? g : h;
    dx = (xds == 2'd0) ? f : (xds == 2'd1) ? g : (xds == 2'd2) ? h : di;
    dy = (yds == 2'd0) ? f : (yds == 2'd1) ? g : (yds == 2'd2) ? h : di;
    chk(x, ex, {tag, " R1 R2 R3 x"});
    chk(y, ey, {tag, " R1 R2 R3 y"});
    if (cur_cfg[49] && sri)        exq = cur_cfg[48];
    else if (!cur_cfg[50] || eci)  exq = dx;
    if (cur_cfg[52] && sri)        eyq = cur_cfg[51];
    else if (!cur_cfg[53] || eci)  eyq = dy;
    @(posedge clk); @(negedge clk);
    #1;
    chk(xq, exq, {tag, " R4 R5 R6 xq"});
    chk(yq, eyq, {tag, " R4 R5 R6 yq"});
  endtask

  task automatic load(input logic [CW-1:0] v);
    bit quiet = 1'b1;
    prog_en = 1'b1;
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_din = v[i];
      #1;
      if (x | y | xq | yq) quiet = 1'b0;
      @(negedge clk);
    end
    prog_en = 1'b0;
    cfg_din = 1'b0;
    cur_cfg = v;
    exq = 1'b0; eyq = 1'b0;
    #1;
    chk(quiet, 1'b1, "R8 outputs low while programming");
    chk(xq, 1'b0, "R8 xq cleared by programming");
    chk(yq, 1'b0, "R8 yq cleared by programming");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    // R9 reset state
    chk(x, 1'b0, "R9 x in reset"); chk(y, 1'b0, "R9 y in reset");
    chk(xq, 1'b0, "R9 xq in reset"); chk(yq, 1'b0, "R9 yq in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, "R9 empty config");

    // Table walk: each configuration with random input vectors
    for (int c = 0; c < NV; c++) begin
      load(CFGS[c]);
      for (int k = 0; k < 40; k++) begin
        apply(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 4) == 0, 1'($urandom), "table");
      end
    end

    // R7: config holds while prog_en low, cfg_din toggling
    load(CFGS[2]);
    for (int k = 0; k < 16; k++) begin
      cfg_din = ~cfg_din;
      apply(4'(k), 4'(15 - k), 1'(k), 1'(k >> 1), 1'b0, 1'b1, "R7 hold");
    end

    // R5/R6 directed: X set-mode, Y reset-mode, both with clock enable
    load(CFGS[1]);
    apply(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 enabled load");
    chk(xq, 1'b0, "R4 xq takes F(0)=0");
    chk(yq, 1'b1, "R4 yq takes G(0)=1");
    apply(4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 hold");
    chk(xq, 1'b0, "R5 xq held"); chk(yq, 1'b1, "R5 yq held");
    apply(4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 sr over ec");
    chk(xq, 1'b1, "R6 xq set"); chk(yq, 1'b0, "R6 yq reset");

    // R5: clock enable ignored when unused (config 0)
    load(CFGS[0]);
    apply(4'h1, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, "R5 ec ignored");
    chk(xq, 1'b1, "R5 xq from H ignoring ec and sr");
    chk(yq, 1'b1, "R5 yq from din ignoring ec and sr");

    // R9: reset mid-run clears config and flops
    rst_n = 1'b0;
    #1;
    chk(xq, 1'b0, "R9 xq after reset"); chk(yq, 1'b0, "R9 yq after reset");
    cur_cfg = '0; exq = 1'b0; eyq = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(4'h1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, "R9 config cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule